// File: doc/BRIEF.md
# I2C Master Control Front End

This block is the software-facing half of an I2C master controller. It decodes a 32-bit register bus and holds the controller's configuration: master/start/stop/NACK requests, the target address, four bus-timing values, transmit and receive byte-count settings, and the bus-control bits that run or park the bit engine. One data offset serves both directions. A write pushes into a small transmit FIFO and a read pops a small receive FIFO. A separate bit-level engine drains the transmit FIFO, fills the receive FIFO and reports its events.

Engine events land in sticky interrupt flags. Writing ones to a clear register removes them, and a level interrupt is raised whenever a flag and its enable are both set. A forced bus reset can be requested. It stays pending until the engine reports completion. While the engine is enabled, the timing values it sees are frozen, so software can only retime the bus after parking it.

Top module: `i2c_ctl_frontend`

## Requirements
- R1: The control register at 0x00 holds four bits: NACK-next-byte at bit 0, stop request at bit 1, start request at bit 2 and master mode at bit 3. Each bit drives its own output and reads back as written. All four are 0 after reset.
- R2: A write to 0x04 pushes wdata[8:0] into the transmit FIFO, where bit 8 marks an address command whose bit 0 is the read flag and bits 7:1 the 7-bit address. The engine sees the oldest entry on `tx_word` with `tx_avail`, and `tx_take` removes it. Entries leave in write order, and a write to a full FIFO is dropped.
- R3: A read of 0x04 returns the oldest receive byte in bits 7:0 and removes it. A read of an empty receive FIFO returns 0 and removes nothing. A byte offered on `rx_put` while the receive FIFO is full is dropped.
- R4: The status register at 0x2C is read-only and reports these bits: TX empty at bit 0, TX not full at bit 1, RX not empty at bit 2, RX full at bit 3, bus busy at bit 8, and device busy at bit 12. Device busy is set by the `dev_busy` input or by a pending forced reset.
- R5: The interrupt flags at 0x20 are set by engine events and stay set until cleared. The flags are arbitration lost at bit 1 (`ev_arb`), no answer at bit 2 (`ev_nack`), requested bytes received at bit 4 (`ev_done`), and TX FIFO empty at bit 9 (set when a take leaves the transmit FIFO empty).
- R6: Writing ones to 0x28 clears the matching flags. An event that arrives in the same cycle as its clear leaves the flag set. Reads of 0x28 return 0.
- R7: The enable register at 0x24 uses the flag layout of R5, and only those four bits are stored. `irq` is high exactly when some flag and its enable are both set.
- R8: In the reset register at 0x34, writing bit 2 empties the transmit FIFO and writing bit 1 empties the receive FIFO. Both bits read as 0.
- R9: Writing bit 0 of 0x34 empties both FIFOs and raises `force_reset`, which also reads back at bit 0. The bit clears itself in the cycle after `force_reset_done`.
- R10: The target address (0x0C, 7 bits) and the transmit and receive byte counts (0x40 and 0x44, 8 bits each) read back what was written and drive their outputs. Offsets 0x48 and 0x4C read the `tx_count_mon` and `rx_count_mon` inputs.
- R11: The bus-control register at 0x50 drives `scl_release` from bit 0 and `eng_run` from bit 1. The timing registers at 0x10, 0x14, 0x18 and 0x1C (16 bits each) read back at once, but they reach `tim_cycle`, `tim_low`, `tim_susto` and `tim_sudat` one cycle later, and only while `eng_run` is 0.
- R12: Offsets 0x08, 0x30, 0x38, 0x3C and every undecoded offset read 0. Writes to them, and to 0x2C, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX at 0x04) |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 1 | Level interrupt |
| ctl_master | output | 1 | Master mode request |
| ctl_start | output | 1 | Start condition request |
| ctl_stop | output | 1 | Stop condition request |
| ctl_nack | output | 1 | NACK the next received byte |
| tgt_addr | output | 7 | Target address |
| tim_cycle | output | 16 | SCL cycle length |
| tim_low | output | 16 | SCL low period |
| tim_susto | output | 16 | Restart/stop setup time |
| tim_sudat | output | 16 | Data setup time |
| tx_count_cfg | output | 8 | Transmit byte count setting |
| rx_count_cfg | output | 8 | Receive byte count setting |
| eng_run | output | 1 | Engine normal operation enable |
| scl_release | output | 1 | Release a held-low SCL |
| tx_word | output | 9 | Oldest transmit entry |
| tx_avail | output | 1 | Transmit FIFO not empty |
| tx_take | input | 1 | Engine consumes the transmit entry |
| rx_byte | input | 8 | Received byte from engine |
| rx_put | input | 1 | Engine pushes a received byte |
| ev_done | input | 1 | Requested bytes received event |
| ev_nack | input | 1 | No-answer event |
| ev_arb | input | 1 | Arbitration lost event |
| dev_busy | input | 1 | Engine busy |
| bus_busy | input | 1 | Bus busy |
| tx_count_mon | input | 8 | Transmit byte count monitor |
| rx_count_mon | input | 8 | Receive byte count monitor |
| force_reset | output | 1 | Forced bus reset request |
| force_reset_done | input | 1 | Engine finished the forced reset |

## Verification
The hardest situation to reach from the ports is a collision of two same-cycle actions, where only one of them can win. One case is an engine event arriving in the very cycle software clears its flag. Another is a timing write landing while the engine runs, followed by the engine being parked. The bench drives the event input and the clear write on the same negative edge. It then writes timing values with `eng_run` high and holds several cycles before parking, checking the engine-side outputs at each step. The TX-empty flag only rises when a take drains the last entry, so the bench fills the transmit FIFO to overflow and drains it entry by entry.

// File: rtl/i2c_fe_pkg.sv
package i2c_fe_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_DATA  = 8'h04;
  localparam logic [7:0] OFS_TADDR = 8'h0C;
  localparam logic [7:0] OFS_ISTAT = 8'h20;
  localparam logic [7:0] OFS_IEN   = 8'h24;
  localparam logic [7:0] OFS_ICLR  = 8'h28;
  localparam logic [7:0] OFS_STAT  = 8'h2C;
  localparam logic [7:0] OFS_RSTC  = 8'h34;
  localparam logic [7:0] OFS_TXCNT = 8'h40;
  localparam logic [7:0] OFS_RXCNT = 8'h44;
  localparam logic [7:0] OFS_TXMON = 8'h48;
  localparam logic [7:0] OFS_RXMON = 8'h4C;
  localparam logic [7:0] OFS_BCTL  = 8'h50;

  localparam int NUM_TIM = 4;  // cycle, low, restart/stop setup, data setup

  localparam int IB_ARB  = 1;
  localparam int IB_NOAN = 2;
  localparam int IB_DONE = 4;
  localparam int IB_TXE  = 9;
  localparam logic [31:0] IRQ_MASK =
    (32'd1 << IB_ARB) | (32'd1 << IB_NOAN) | (32'd1 << IB_DONE) | (32'd1 << IB_TXE);

  // timing registers live at 0x10..0x1C
  function automatic logic is_tim(input logic [7:0] a);
    return (a[7:4] == 4'h1) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [31:0] pack_status(input logic dbusy, input logic bbusy,
                                              input logic rxf, input logic rxne,
                                              input logic txnf, input logic txe);
    logic [31:0] s;
    s = '0;
    s[12] = dbusy;
    s[8]  = bbusy;
    s[3]  = rxf;
    s[2]  = rxne;
    s[1]  = txnf;
    s[0]  = txe;
    return s;
  endfunction

  function automatic logic [31:0] flag_next(input logic [31:0] cur, input logic [31:0] set,
                                            input logic [31:0] clr);
    return ((cur & ~clr) | set) & IRQ_MASK;
  endfunction

  function automatic logic [31:0] build_events(input logic txe, input logic done,
                                               input logic noan, input logic arb);
    logic [31:0] e;
    e = '0;
    e[IB_TXE]  = txe;
    e[IB_DONE] = done;
    e[IB_NOAN] = noan;
    e[IB_ARB]  = arb;
    return e;
  endfunction
endpackage

// File: rtl/i2c_fe_fifo.sv
module i2c_fe_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full,
  output logic         drained
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign drained = do_pop && !do_push && (count == CW'(1));
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R2
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (full && $stable(wr_ptr))); // R2
endmodule

// File: rtl/i2c_fe_irq.sv
module i2c_fe_irq
  import i2c_fe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] set_vec,
  input  logic        clr_wr,
  input  logic [31:0] clr_vec,
  input  logic        en_wr,
  input  logic [31:0] en_vec,
  output logic [31:0] status,
  output logic [31:0] enable,
  output logic        irq
);
  logic [31:0] clr_eff;
  assign clr_eff = clr_wr ? clr_vec : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= flag_next(status, set_vec, clr_eff);
      if (en_wr) enable <= en_vec & IRQ_MASK;
    end
  end

  assign irq = |(status & enable);

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_vec & IRQ_MASK)) |=> ((status & $past(set_vec & IRQ_MASK)) == $past(set_vec & IRQ_MASK))); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(status & ~clr_eff)) == $past(status & ~clr_eff))); // R5
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((status & $past(clr_vec & ~set_vec)) == 32'd0)); // R6
endmodule

// File: rtl/i2c_ctl_frontend.sv
module i2c_ctl_frontend
  import i2c_fe_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int TIM_W    = 16,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq,
  output logic             ctl_master,
  output logic             ctl_start,
  output logic             ctl_stop,
  output logic             ctl_nack,
  output logic [6:0]       tgt_addr,
  output logic [TIM_W-1:0] tim_cycle,
  output logic [TIM_W-1:0] tim_low,
  output logic [TIM_W-1:0] tim_susto,
  output logic [TIM_W-1:0] tim_sudat,
  output logic [CNT_W-1:0] tx_count_cfg,
  output logic [CNT_W-1:0] rx_count_cfg,
  output logic             eng_run,
  output logic             scl_release,
  output logic [8:0]       tx_word,
  output logic             tx_avail,
  input  logic             tx_take,
  input  logic [7:0]       rx_byte,
  input  logic             rx_put,
  input  logic             ev_done,
  input  logic             ev_nack,
  input  logic             ev_arb,
  input  logic             dev_busy,
  input  logic             bus_busy,
  input  logic [CNT_W-1:0] tx_count_mon,
  input  logic [CNT_W-1:0] rx_count_mon,
  output logic             force_reset,
  input  logic             force_reset_done
);
  localparam int TX_W = 9;
  localparam int RX_W = 8;

  // ---------------- decode ----------------
  logic wr_ctrl, wr_data, wr_taddr, wr_ien, wr_iclr, wr_rstc, wr_txcnt, wr_rxcnt, wr_bctl;
  logic rd_data;
  assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_data  = bus_wr && (bus_addr == OFS_DATA);
  assign wr_taddr = bus_wr && (bus_addr == OFS_TADDR);
  assign wr_ien   = bus_wr && (bus_addr == OFS_IEN);
  assign wr_iclr  = bus_wr && (bus_addr == OFS_ICLR);
  assign wr_rstc  = bus_wr && (bus_addr == OFS_RSTC);
  assign wr_txcnt = bus_wr && (bus_addr == OFS_TXCNT);
  assign wr_rxcnt = bus_wr && (bus_addr == OFS_RXCNT);
  assign wr_bctl  = bus_wr && (bus_addr == OFS_BCTL);
  assign rd_data  = bus_rd && (bus_addr == OFS_DATA);

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  // ---------------- simple registers ----------------
  logic [3:0]       ctrl_q;
  logic [6:0]       taddr_q;
  logic [CNT_W-1:0] txcnt_q, rxcnt_q;
  logic [1:0]       bctl_q;
  logic             force_pend;
  logic             force_arm;     // software asks for a forced reset this cycle
  logic             flush_tx, flush_rx;

  assign force_arm = wr_rstc && bus_wdata[0];
  assign flush_tx  = wr_rstc && (bus_wdata[2] || bus_wdata[0]);
  assign flush_rx  = wr_rstc && (bus_wdata[1] || bus_wdata[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      taddr_q    <= '0;
      txcnt_q    <= '0;
      rxcnt_q    <= '0;
      bctl_q     <= '0;
      force_pend <= 1'b0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= bus_wdata[3:0];
      if (wr_taddr) taddr_q <= bus_wdata[6:0];
      if (wr_txcnt) txcnt_q <= bus_wdata[CNT_W-1:0];
      if (wr_rxcnt) rxcnt_q <= bus_wdata[CNT_W-1:0];
      if (wr_bctl)  bctl_q  <= bus_wdata[1:0];
      if (force_arm)             force_pend <= 1'b1;
      else if (force_reset_done) force_pend <= 1'b0;
    end
  end

  assign ctl_nack     = ctrl_q[0];
  assign ctl_stop     = ctrl_q[1];
  assign ctl_start    = ctrl_q[2];
  assign ctl_master   = ctrl_q[3];
  assign tgt_addr     = taddr_q;
  assign tx_count_cfg = txcnt_q;
  assign rx_count_cfg = rxcnt_q;
  assign scl_release  = bctl_q[0];
  assign eng_run      = bctl_q[1];
  assign force_reset  = force_pend;

  // ---------------- timing registers with engine-side copies ----------------
  logic [TIM_W-1:0] tim_reg [NUM_TIM];
  logic [TIM_W-1:0] tim_out [NUM_TIM];

  for (genvar gi = 0; gi < NUM_TIM; gi++) begin : g_tim
    logic wr_this;
    assign wr_this = bus_wr && is_tim(bus_addr) && (bus_addr[3:2] == 2'(gi));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tim_reg[gi] <= '0;
        tim_out[gi] <= '0;
      end else begin
        if (wr_this) tim_reg[gi] <= bus_wdata[TIM_W-1:0];
        if (!eng_run) tim_out[gi] <= tim_reg[gi];
      end
    end
  end

  assign tim_cycle = tim_out[0];
  assign tim_low   = tim_out[1];
  assign tim_susto = tim_out[2];
  assign tim_sudat = tim_out[3];

  // ---------------- FIFOs ----------------
  logic [TX_W-1:0] tx_head;
  logic [RX_W-1:0] rx_head;
  logic tx_empty, tx_full, tx_drained;
  logic rx_empty, rx_full, rx_drained_unused;

  i2c_fe_fifo #(.W(TX_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush_tx),
    .push(wr_data), .wdata(bus_wdata[TX_W-1:0]),
    .pop(tx_take), .rdata(tx_head),
    .empty(tx_empty), .full(tx_full), .drained(tx_drained)
  );

  i2c_fe_fifo #(.W(RX_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush_rx),
    .push(rx_put), .wdata(rx_byte),
    .pop(rd_data), .rdata(rx_head),
    .empty(rx_empty), .full(rx_full), .drained(rx_drained_unused)
  );

  assign tx_word  = tx_head;
  assign tx_avail = !tx_empty;

  // ---------------- interrupts ----------------
  logic [31:0] ev_vec, istat, ien;
  assign ev_vec = build_events(tx_drained, ev_done, ev_nack, ev_arb);

  i2c_fe_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_vec(ev_vec),
    .clr_wr(wr_iclr), .clr_vec(bus_wdata),
    .en_wr(wr_ien), .en_vec(bus_wdata),
    .status(istat), .enable(ien), .irq(irq)
  );

  // ---------------- read mux ----------------
  logic [31:0] status_word;
  assign status_word = pack_status(dev_busy || force_pend, bus_busy,
                                   rx_full, !rx_empty, !tx_full, tx_empty);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (is_tim(bus_addr)) begin
        bus_rdata = 32'(tim_reg[bus_addr[3:2]]);
      end else begin
        case (bus_addr)
          OFS_CTRL:  bus_rdata = 32'(ctrl_q);
          OFS_DATA:  bus_rdata = rx_empty ? '0 : 32'(rx_head);
          OFS_TADDR: bus_rdata = 32'(taddr_q);
          OFS_ISTAT: bus_rdata = istat;
          OFS_IEN:   bus_rdata = ien;
          OFS_STAT:  bus_rdata = status_word;
          OFS_RSTC:  bus_rdata = 32'(force_pend);
          OFS_TXCNT: bus_rdata = 32'(txcnt_q);
          OFS_RXCNT: bus_rdata = 32'(rxcnt_q);
          OFS_TXMON: bus_rdata = 32'(tx_count_mon);
          OFS_RXMON: bus_rdata = 32'(rx_count_mon);
          OFS_BCTL:  bus_rdata = 32'(bctl_q);
          default:   bus_rdata = '0;
        endcase
      end
    end
  end

  // ---------------- assertions ----------------
  AST_FORCE_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (force_reset && force_reset_done && !force_arm) |=> !force_reset); // R9
  AST_FORCE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (force_reset && !force_reset_done) |=> force_reset); // R9
  AST_TIM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eng_run) |-> ($stable(tim_cycle) && $stable(tim_low)
                        && $stable(tim_susto) && $stable(tim_sudat))); // R11
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable({ctl_master, ctl_start, ctl_stop, ctl_nack})); // R1
endmodule

// File: tb/tb_i2c_ctl_frontend.sv
module tb_i2c_ctl_frontend;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, ctl_master, ctl_start, ctl_stop, ctl_nack;
  logic [6:0] tgt_addr;
  logic [15:0] tim_cycle, tim_low, tim_susto, tim_sudat;
  logic [7:0] tx_count_cfg, rx_count_cfg;
  logic eng_run, scl_release;
  logic [8:0] tx_word;
  logic tx_avail;
  logic tx_take = 0, rx_put = 0, ev_done = 0, ev_nack = 0, ev_arb = 0;
  logic dev_busy = 0, bus_busy = 0, force_reset_done = 0;
  logic [7:0] rx_byte = 0, tx_count_mon = 0, rx_count_mon = 0;
  logic force_reset;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_ctl_frontend dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [31:0] flag_of(input int k);
    case (k)
      0: return 32'h002;
      1: return 32'h004;
      2: return 32'h010;
      default: return 32'h200;
    endcase
  endfunction

  task automatic fire(input int k);
    if (k == 0) ev_arb = 1;
    else if (k == 1) ev_nack = 1;
    else if (k == 2) ev_done = 1;
    else begin
      wr(8'h04, 32'h0AB);
      tx_take = 1;
    end
    tick();
    ev_arb = 0; ev_nack = 0; ev_done = 0; tx_take = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    rdchk("R1 reset ctrl", 8'h00, 0);
    rdchk("R4 reset status", 8'h2C, 32'h3);
    check("R7 reset irq", irq, 0);
    check("R9 reset force", force_reset, 0);

    // R1 control sweep
    for (int v = 0; v < 16; v++) begin
      wr(8'h00, 32'hFFFFFFF0 | v);
      check("R1 outputs", {ctl_master, ctl_start, ctl_stop, ctl_nack}, v);
      rdchk("R1 readback", 8'h00, v);
    end
    wr(8'h00, 0);

    // R2 transmit FIFO: address command then data, one overflow
    wr(8'h04, 32'h100 | (32'h52 << 1) | 1);
    for (int i = 1; i <= 4; i++) wr(8'h04, 32'h11 * i);
    rdchk("R4 tx full status", 8'h2C, 32'h0);
    for (int i = 0; i < 4; i++) begin
      check("R2 avail", tx_avail, 1);
      check("R2 order", tx_word, (i == 0) ? 32'h1A5 : 32'h11 * i);
      tx_take = 1; tick(); tx_take = 0;
    end
    check("R2 empty after drain", tx_avail, 0);
    rdchk("R5 tx empty flag", 8'h20, 32'h200);
    rdchk("R4 tx empty status", 8'h2C, 32'h3);
    wr(8'h28, 32'hFFFFFFFF);
    rdchk("R6 cleared", 8'h20, 0);

    // R3 receive FIFO with overflow
    for (int i = 0; i < 5; i++) begin
      rx_byte = 8'(8'hC0 + i); rx_put = 1; tick();
    end
    rx_put = 0;
    rdchk("R4 rx full status", 8'h2C, 32'h3 | 32'hC);
    for (int i = 0; i < 4; i++) rdchk("R3 rx order", 8'h04, 32'hC0 + i);
    rdchk("R3 empty read", 8'h04, 0);
    rdchk("R3 empty status", 8'h2C, 32'h3);

    // R5/R6 each event, set then clear; same-cycle event and clear
    for (int k = 0; k < 4; k++) begin
      fire(k);
      rdchk("R5 flag set", 8'h20, flag_of(k));
      tick();
      rdchk("R5 flag sticky", 8'h20, flag_of(k));
      bus_wr = 1; bus_addr = 8'h28; bus_wdata = flag_of(k);
      if (k == 0) ev_arb = 1;
      else if (k == 1) ev_nack = 1;
      else if (k == 2) ev_done = 1;
      tick();
      bus_wr = 0; ev_arb = 0; ev_nack = 0; ev_done = 0;
      rdchk("R6 event beats clear", 8'h20, (k < 3) ? flag_of(k) : 0);
      wr(8'h28, flag_of(k));
      rdchk("R6 clear", 8'h20, 0);
    end
    rdchk("R6 clear reg reads zero", 8'h28, 0);

    // R7 enable sweep
    for (int k = 0; k < 4; k++) fire(k);
    rdchk("R5 all flags", 8'h20, 32'h216);
    for (int e = 0; e < 16; e++) begin
      logic [31:0] m;
      m = 0;
      for (int b = 0; b < 4; b++) if (e[b]) m |= flag_of(b);
      wr(8'h24, m | 32'h00FF_0000);
      rdchk("R7 enable readback", 8'h24, m);
      check("R7 irq all set", irq, e != 0);
    end
    wr(8'h28, 32'h214);
    for (int e = 0; e < 16; e++) begin
      logic [31:0] m;
      m = 0;
      for (int b = 0; b < 4; b++) if (e[b]) m |= flag_of(b);
      wr(8'h24, m);
      check("R7 irq only arb", irq, e[0]);
    end
    wr(8'h28, 32'hFFFFFFFF);
    check("R7 irq after clear", irq, 0);

    // R8 separate flushes
    wr(8'h04, 32'h33);
    rx_byte = 8'h5A; rx_put = 1; tick(); rx_put = 0;
    wr(8'h34, 32'h4);
    rdchk("R8 tx flushed", 8'h2C, 32'h3 | 32'h4);
    wr(8'h34, 32'h2);
    rdchk("R8 rx flushed", 8'h2C, 32'h3);
    rdchk("R8 reads zero", 8'h34, 0);

    // R9 forced reset
    wr(8'h04, 32'h44);
    rx_byte = 8'h66; rx_put = 1; tick(); rx_put = 0;
    wr(8'h34, 32'h1);
    check("R9 request", force_reset, 1);
    rdchk("R9 both flushed, busy", 8'h2C, 32'h1003);
    repeat (3) tick();
    rdchk("R9 pending readback", 8'h34, 1);
    force_reset_done = 1; tick(); force_reset_done = 0;
    check("R9 self clear", force_reset, 0);
    dev_busy = 1; bus_busy = 1;
    #1 rdchk("R4 busy bits", 8'h2C, 32'h1103);
    dev_busy = 0; bus_busy = 0;

    // R10 address, counts, monitors
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = 32'h9E37_79B9 * (i + 1);
      wr(8'h0C, v); rdchk("R10 taddr", 8'h0C, v & 32'h7F);
      check("R10 taddr out", tgt_addr, v & 32'h7F);
      wr(8'h40, v); rdchk("R10 txcnt", 8'h40, v & 32'hFF);
      wr(8'h44, ~v); rdchk("R10 rxcnt", 8'h44, ~v & 32'hFF);
      check("R10 cnt out", {tx_count_cfg, rx_count_cfg}, {v[7:0], ~v[7:0]});
      tx_count_mon = v[15:8]; rx_count_mon = v[23:16];
      rdchk("R10 txmon", 8'h48, v[15:8]);
      rdchk("R10 rxmon", 8'h4C, v[23:16]);
    end

    // R11 bus control and timing freeze
    for (int b = 0; b < 4; b++) begin
      wr(8'h50, b);
      check("R11 bctl outputs", {eng_run, scl_release}, b);
      rdchk("R11 bctl readback", 8'h50, b);
    end
    wr(8'h50, 0);
    for (int t = 0; t < 4; t++) wr(8'h10 + 8'(4 * t), 32'h1000 + t);
    tick();
    check("R11 idle copies", {tim_cycle, tim_low, tim_susto, tim_sudat},
          {16'h1000, 16'h1001, 16'h1002, 16'h1003});
    wr(8'h50, 2);
    for (int t = 0; t < 4; t++) wr(8'h10 + 8'(4 * t), 32'hABCD_0200 + t);
    for (int t = 0; t < 4; t++) rdchk("R11 reg readback", 8'h10 + 8'(4 * t), 32'h0200 + t);
    repeat (3) tick();
    check("R11 frozen while running", {tim_cycle, tim_low, tim_susto, tim_sudat},
          {16'h1000, 16'h1001, 16'h1002, 16'h1003});
    wr(8'h50, 0);
    tick();
    check("R11 copies after park", {tim_cycle, tim_low, tim_susto, tim_sudat},
          {16'h0200, 16'h0201, 16'h0202, 16'h0203});

    // R12 holes and read-only offsets
    wr(8'h00, 32'h5);
    foreach (d[i]) ;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] a;
      a = (i == 0) ? 8'h08 : (i == 1) ? 8'h30 : (i == 2) ? 8'h38 :
          (i == 3) ? 8'h3C : (i == 4) ? 8'h2C : 8'h7C;
      wr(a, 32'hFFFFFFFF);
      if (i != 4) rdchk("R12 hole reads zero", a, 0);
    end
    rdchk("R12 ctrl untouched", 8'h00, 5);
    rdchk("R12 status untouched", 8'h2C, 32'h3);
    rdchk("R12 flags untouched", 8'h20, 0);
    rdchk("R12 bctl untouched", 8'h50, 0);
    rdchk("R12 timing untouched", 8'h10, 32'h0200);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule